// File: doc/BRIEF.md
# SCSI Target Command-Phase Byte Receiver

This block sits on the target side of a SCSI bus while the bus is in Command Phase. The host starts it by writing a receive-command code together with a one-cycle start pulse. The block then takes command descriptor bytes from the initiator as a simple valid/data stream, where every byte carries its own parity bit. Each good byte goes into a small byte FIFO, and the host or a DMA engine drains that FIFO.

The first byte decides how long the command block is. Its three most significant bits form a group code. That group code selects a fixed total length, and a transfer counter is loaded from that length. If the group is not recognised, the counter falls back to a default length and the group-valid flag is cleared. Each later byte decrements the counter. When the counter reaches zero, the command ends with a completion interrupt.

The command can also end early. If the initiator asserts attention, the block raises a service-request interrupt and stops. If a byte arrives with bad parity, the block raises a parity-error flag and stops. All flags are sticky until the host pulses the clear input. The busy output shows whether the command register is still occupied.

Top module: `scsi_cmd_rx`

## Requirements
- R1: A pulse on `cmd_start` while idle starts a command only when `cmd_code` is 8'h2B or 8'hAB (bit 7 selects DMA mode). Any other code leaves `busy` low. A start pulse while busy is ignored.
- R2: The group code is bits 7:5 of the first byte. Group 0 gives a length of 6, groups 1 and 2 give 10, and group 5 gives 12. For these groups, `xfer_cnt` shows the length minus one after the first byte is taken, and `st_gcv` is set.
- R3: Groups 3, 4, 6 and 7 are unknown. For these, the length is 5, so `xfer_cnt` shows 4 after the first byte, and `st_gcv` is cleared.
- R4: Each later accepted byte decrements `xfer_cnt`. The byte that brings it to zero ends the command: `busy` falls and `irq_done` is set.
- R5: A byte is good when its 8 data bits plus `rx_par` hold an odd number of ones. A byte that fails this check is not stored, sets `st_par_err`, and ends the command.
- R6: `atn` high while busy sets `irq_svc` and ends the command. A byte offered in that same cycle is discarded.
- R7: Good bytes enter a 16-deep FIFO in arrival order. `fifo_data` shows the oldest byte, `fifo_pop` removes it, and `fifo_level` gives the number of bytes held.
- R8: A good byte that arrives while the FIFO is full is dropped and sets `st_ovf`. `fifo_level` stays at 16, but the byte still counts toward the command length.
- R9: `st_gcv`, `st_par_err`, `st_ovf`, `irq_svc` and `irq_done` keep their value until a `clr_status` pulse clears them all.
- R10: Bytes offered while no command is active are ignored. The FIFO level does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_code | input | 8 | Host command code |
| cmd_start | input | 1 | One-cycle strobe that issues `cmd_code` |
| clr_status | input | 1 | Clears all sticky flags |
| rx_valid | input | 1 | A command byte is offered this cycle |
| rx_data | input | 8 | Command byte |
| rx_par | input | 1 | Odd parity bit of `rx_data` |
| atn | input | 1 | Initiator attention line |
| fifo_pop | input | 1 | Removes the oldest FIFO byte |
| fifo_data | output | 8 | Oldest FIFO byte |
| fifo_level | output | 5 | Bytes held in the FIFO |
| busy | output | 1 | Command is active |
| xfer_cnt | output | 5 | Bytes still expected |
| st_gcv | output | 1 | Group code was recognised |
| st_par_err | output | 1 | Parity error seen |
| st_ovf | output | 1 | FIFO overflow seen |
| irq_svc | output | 1 | Service request (attention) |
| irq_done | output | 1 | Command completed normally |

## Verification
The bench builds the block with its default parameters: a 16-entry FIFO, odd parity and a fallback length of 5. With a 16-entry FIFO, two back-to-back 12-byte commands (24 bytes, no draining) are enough to reach the overflow path. With odd parity, one flipped parity bit is enough to reach the parity-error path. All eight group codes pass through the length decoder, so both the known lengths and the fallback path are covered.

// File: rtl/scsi_cmdrx_pkg.sv
// Shared types for the command-phase receiver.
// Assumes the length counter never needs more than LEN_W bits.
package scsi_cmdrx_pkg;
    localparam int LEN_W = 5;

    // Result of decoding a group code.
    typedef struct packed {
        logic             known;
        logic [LEN_W-1:0] len;
    } grp_info_t;

    // Controller phases.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRST = 2'd1,
        ST_REST  = 2'd2
    } rx_state_t;
endpackage

// File: rtl/scsi_cmdrx_grp_decode.sv
// Maps a 3-bit group code to the total command-block length.
// Unknown groups return FALLBACK_LEN with known cleared.
// Purely combinational.
module scsi_cmdrx_grp_decode
    import scsi_cmdrx_pkg::*;
#(
    parameter int FALLBACK_LEN = 5
) (
    input  logic [2:0] grp,
    output grp_info_t  info
);
    // Length lookup for each group code.
    always_comb begin
        info.known = 1'b1;
        case (grp)
            3'd0:       info.len = LEN_W'(6);
            3'd1, 3'd2: info.len = LEN_W'(10);
            3'd5:       info.len = LEN_W'(12);
            default: begin
                info.known = 1'b0;
                info.len   = LEN_W'(FALLBACK_LEN);
            end
        endcase
    end
endmodule

// File: rtl/scsi_cmdrx_parity.sv
// Parity checker for one received byte.
// ODD=1 accepts an odd number of ones over data plus parity bit;
// ODD=0 accepts an even number of ones.
module scsi_cmdrx_parity #(
    parameter int DATA_W = 8,
    parameter bit ODD    = 1'b1
) (
    input  logic [DATA_W-1:0] data,
    input  logic              par,
    output logic              ok
);
    logic ones_odd;

    // Reduction over the whole protected word.
    assign ones_odd = ^{data, par};

    generate
        if (ODD) begin : g_odd
            assign ok = ones_odd;
        end else begin : g_even
            assign ok = ~ones_odd;
        end
    endgenerate
endmodule

// File: rtl/scsi_cmdrx_fifo.sv
// Show-ahead byte FIFO.
// A push while full is dropped, even if a pop happens in the same cycle,
// and raises ovf_evt for that cycle.
// Assumes DEPTH is a power of two.
module scsi_cmdrx_fifo #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] dout,
    output logic [CW-1:0]     count,
    output logic              ovf_evt
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic              full, empty, do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign ovf_evt = push && full;
    assign dout    = mem[rd_ptr];

    // Storage write; no reset needed for the data array.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // A blocked push must not change the occupancy.
    p_full_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (count == CW'(DEPTH)));

    // Occupancy never exceeds the depth.
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
endmodule

// File: rtl/scsi_cmdrx_ctrl.sv
// Sequencer for the receive-command operation.
// Takes the decoded group info of the current byte, tracks remaining length
// and holds the sticky status and interrupt flags.
// Attention has priority over a byte offered in the same cycle; a parity
// error has priority over counting.
module scsi_cmdrx_ctrl
    import scsi_cmdrx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       cmd_code,
    input  logic             cmd_start,
    input  logic             clr_status,
    input  logic             rx_valid,
    input  logic             par_ok,
    input  logic             atn,
    input  grp_info_t        info,
    input  logic             ovf_evt,
    output logic             push,
    output logic             busy,
    output logic [LEN_W-1:0] xfer_cnt,
    output logic             st_gcv,
    output logic             st_par_err,
    output logic             st_ovf,
    output logic             irq_svc,
    output logic             irq_done
);
    rx_state_t state;
    logic      cmd_ok, take;

    assign cmd_ok = (cmd_code == 8'h2B) || (cmd_code == 8'hAB);
    assign busy   = (state != ST_IDLE);
    assign take   = busy && !atn && rx_valid;
    assign push   = take && par_ok;

    // Phase, length counter and sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            xfer_cnt   <= '0;
            st_gcv     <= 1'b0;
            st_par_err <= 1'b0;
            st_ovf     <= 1'b0;
            irq_svc    <= 1'b0;
            irq_done   <= 1'b0;
        end else begin
            if (clr_status) begin
                st_gcv     <= 1'b0;
                st_par_err <= 1'b0;
                st_ovf     <= 1'b0;
                irq_svc    <= 1'b0;
                irq_done   <= 1'b0;
            end
            case (state)
                ST_IDLE: begin
                    if (cmd_start && cmd_ok) state <= ST_FIRST;
                end
                default: begin
                    if (atn) begin
                        irq_svc <= 1'b1;
                        state   <= ST_IDLE;
                    end else if (rx_valid) begin
                        if (!par_ok) begin
                            st_par_err <= 1'b1;
                            state      <= ST_IDLE;
                        end else if (state == ST_FIRST) begin
                            xfer_cnt <= info.len - 1'b1;
                            st_gcv   <= info.known;
                            state    <= ST_REST;
                        end else begin
                            xfer_cnt <= xfer_cnt - 1'b1;
                            if (xfer_cnt == LEN_W'(1)) begin
                                irq_done <= 1'b1;
                                state    <= ST_IDLE;
                            end
                        end
                    end
                end
            endcase
            if (ovf_evt) st_ovf <= 1'b1;
        end
    end

    p_bad_code_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_start && !cmd_ok) |=> !busy);

    p_known_gcv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIRST && take && par_ok && info.known) |=> st_gcv);

    p_unknown_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIRST && take && par_ok && !info.known)
            |=> (!st_gcv && xfer_cnt == LEN_W'(4)));

    p_end_has_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (irq_done || st_par_err || irq_svc));

    p_par_err_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !par_ok) |=> (st_par_err && !busy));

    p_atn_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && atn) |=> (irq_svc && !busy));

    p_idle_no_push_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !push);
endmodule

// File: rtl/scsi_cmd_rx.sv
// Top of the command-phase receiver.
// Wires the parity checker, the group decoder, the controller and the FIFO.
// The group code is taken from the top three bits of every offered byte;
// the controller uses it only on the first byte.
module scsi_cmd_rx
    import scsi_cmdrx_pkg::*;
#(
    parameter int  FIFO_DEPTH   = 16,
    parameter int  FALLBACK_LEN = 5,
    parameter bit  ODD_PARITY   = 1'b1,
    localparam int DATA_W       = 8,
    localparam int LW           = $clog2(FIFO_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        cmd_code,
    input  logic              cmd_start,
    input  logic              clr_status,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_par,
    input  logic              atn,
    input  logic              fifo_pop,
    output logic [DATA_W-1:0] fifo_data,
    output logic [LW-1:0]     fifo_level,
    output logic              busy,
    output logic [LEN_W-1:0]  xfer_cnt,
    output logic              st_gcv,
    output logic              st_par_err,
    output logic              st_ovf,
    output logic              irq_svc,
    output logic              irq_done
);
    logic      par_ok, push, ovf_evt;
    grp_info_t info;

    scsi_cmdrx_parity #(.DATA_W(DATA_W), .ODD(ODD_PARITY)) u_par (
        .data(rx_data), .par(rx_par), .ok(par_ok)
    );

    scsi_cmdrx_grp_decode #(.FALLBACK_LEN(FALLBACK_LEN)) u_dec (
        .grp(rx_data[DATA_W-1 -: 3]), .info(info)
    );

    scsi_cmdrx_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .cmd_start(cmd_start),
        .clr_status(clr_status), .rx_valid(rx_valid), .par_ok(par_ok),
        .atn(atn), .info(info), .ovf_evt(ovf_evt), .push(push), .busy(busy),
        .xfer_cnt(xfer_cnt), .st_gcv(st_gcv), .st_par_err(st_par_err),
        .st_ovf(st_ovf), .irq_svc(irq_svc), .irq_done(irq_done)
    );

    scsi_cmdrx_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(DATA_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .din(rx_data), .pop(fifo_pop),
        .dout(fifo_data), .count(fifo_level), .ovf_evt(ovf_evt)
    );

    // An overflow event always leaves the sticky flag set.
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> st_ovf);

    // Flags set without a clear stay set.
    p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_done && !clr_status) |=> irq_done);
endmodule

// File: tb/sim_scsi_cmd_rx.sv
`timescale 1ns/1ps
module sim_scsi_cmd_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cmd_code = '0;
    logic       cmd_start = 1'b0, clr_status = 1'b0;
    logic       rx_valid = 1'b0, rx_par = 1'b0, atn = 1'b0, fifo_pop = 1'b0;
    logic [7:0] rx_data = '0;
    logic [7:0] fifo_data;
    logic [4:0] fifo_level, xfer_cnt;
    logic       busy, st_gcv, st_par_err, st_ovf, irq_svc, irq_done;

    int tests = 0, fails = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    scsi_cmd_rx u0 (
        .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .cmd_start(cmd_start),
        .clr_status(clr_status), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_par(rx_par), .atn(atn), .fifo_pop(fifo_pop), .fifo_data(fifo_data),
        .fifo_level(fifo_level), .busy(busy), .xfer_cnt(xfer_cnt),
        .st_gcv(st_gcv), .st_par_err(st_par_err), .st_ovf(st_ovf),
        .irq_svc(irq_svc), .irq_done(irq_done)
    );

    // {first byte, gcv expected, total length}
    localparam logic [12:0] VEC [0:7] = '{
        {8'h03, 1'b1, 4'd6},  {8'h23, 1'b1, 4'd10},
        {8'h43, 1'b1, 4'd10}, {8'h63, 1'b0, 4'd5},
        {8'h83, 1'b0, 4'd5},  {8'hA3, 1'b1, 4'd12},
        {8'hC3, 1'b0, 4'd5},  {8'hE3, 1'b0, 4'd5}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic start(input logic [7:0] code);
        cmd_code = code; cmd_start = 1'b1;
        tick();
        cmd_start = 1'b0;
    endtask

    task automatic send(input logic [7:0] d, input bit bad);
        rx_valid = 1'b1; rx_data = d; rx_par = (~^d) ^ bad;
        tick();
        rx_valid = 1'b0;
    endtask

    task automatic clear();
        clr_status = 1'b1;
        tick();
        clr_status = 1'b0;
    endtask

    task automatic drain();
        while (fifo_level != 0) begin
            fifo_pop = 1'b1;
            tick();
        end
        fifo_pop = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset done", int'(irq_done), 0);
        check("R7 reset level", int'(fifo_level), 0);
        check("R1 reset busy", int'(busy), 0);
        rst_n = 1'b1;
        tick();

        // Table walk over all group codes, alternating both start codes.
        for (int i = 0; i < 8; i++) begin
            logic [7:0] fb;
            int len;
            fb  = VEC[i][12:5];
            len = int'(VEC[i][3:0]);
            start((i % 2 == 0) ? 8'h2B : 8'hAB);
            check("R1 busy after start", int'(busy), 1);
            send(fb, 1'b0);
            check("R2/R3 length", int'(xfer_cnt), len - 1);
            check(VEC[i][4] ? "R2 gcv" : "R3 gcv", int'(st_gcv), int'(VEC[i][4]));
            for (int k = 1; k < len; k++) begin
                check("R4 busy mid", int'(busy), 1);
                send(fb + 8'(k), 1'b0);
            end
            check("R4 done", int'(irq_done), 1);
            check("R4 busy end", int'(busy), 0);
            check("R7 level", int'(fifo_level), len);
            for (int k = 0; k < len; k++) begin
                check("R7 order", int'(fifo_data), int'(fb + 8'(k)));
                fifo_pop = 1'b1;
                tick();
                fifo_pop = 1'b0;
            end
            tick();
            check("R9 done sticky", int'(irq_done), 1);
            clear();
            check("R9 cleared", int'(irq_done), 0);
        end

        // R1: wrong code ignored; R10: idle byte ignored.
        start(8'h2A);
        check("R1 bad code", int'(busy), 0);
        send(8'h11, 1'b0);
        check("R10 idle byte", int'(fifo_level), 0);

        // R5: parity error mid-command.
        start(8'h2B);
        send(8'h03, 1'b0);
        send(8'h55, 1'b1);
        check("R5 perr", int'(st_par_err), 1);
        check("R5 busy", int'(busy), 0);
        check("R5 not stored", int'(fifo_level), 1);
        send(8'h66, 1'b0);
        check("R10 after end", int'(fifo_level), 1);
        drain(); clear();
        check("R9 perr cleared", int'(st_par_err), 0);

        // R6: attention with a byte in the same cycle.
        start(8'hAB);
        send(8'h03, 1'b0);
        atn = 1'b1;
        send(8'h44, 1'b0);
        atn = 1'b0;
        check("R6 svc", int'(irq_svc), 1);
        check("R6 busy", int'(busy), 0);
        check("R6 discarded", int'(fifo_level), 1);
        drain(); clear();

        // R8: two 12-byte commands without draining.
        for (int c = 0; c < 2; c++) begin
            start(8'h2B);
            send(8'hA3, 1'b0);
            for (int k = 1; k < 12; k++) send(8'(k), 1'b0);
            check("R8 command ends", int'(irq_done), 1);
        end
        check("R8 ovf", int'(st_ovf), 1);
        check("R8 level held", int'(fifo_level), 16);
        check("R8 oldest kept", int'(fifo_data), 8'hA3);
        drain(); clear();
        check("R9 ovf cleared", int'(st_ovf), 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule